// File: doc/BRIEF.md
# Predicated Vector Compare Unit

This block gives scalar compare-and-branch encodings and floating-point compare encodings a vector meaning. The decoded operation does not redirect control flow. It compares two source register groups element by element and builds a predicate bitfield, one bit per element. At the end of the operation that bitfield is written once to the predicate register that the instruction names. Both integer branch opcodes and floating-point compare opcodes are decoded. Single and double precision are supported. Invalid-operation events are kept per element and also folded into one summary flag.

The unit works on one element per clock. A caller starts an operation with an instruction word and a vector length. The unit then walks the element index from 0 upward. The caller returns the two operands for the current index on the same cycle. When the last element has been evaluated, the unit pulses `done`. On a legal instruction it also raises a one-cycle predicate write strobe, carrying the destination register number and the finished bitfield. An illegal instruction ends the operation with an error indication and no write.

Top module: `vpred_cmp_unit`

## Requirements
- R1: With bits 6..0 = 1100011, bits 14..12 select an integer compare of `op_a` against `op_b` on XLEN-bit elements: 000 equal, 001 not equal, 100 signed less-or-equal, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal.
- R2: In the integer form, the destination predicate register is bits 11..8, zero-extended to 5 bits. Bits 31..25 must be zero. Funct3 values 010 and 011 are illegal.
- R3: With bits 6..0 = 1010011 and bits 31..27 = 10100, the instruction is a floating-point compare. Bits 14..12 select the compare: 010 equal, 001 less-than, 000 less-or-equal, 011 not equal. Any other funct3 is illegal. The destination register is bits 11..7.
- R4: Floating-point format bits 26..25 select the precision. 00 is single precision, taken from operand bits 31..0. 01 is double precision. 10 and 11 are illegal.
- R5: If either floating-point operand is a NaN, equal, less-than and less-or-equal give 0, and not-equal gives 1.
- R6: An element's `fp_status` bit is set when either operand is a signalling NaN (quiet bit, the top mantissa bit, clear), or when any NaN is present in less-than or less-or-equal. Integer operations leave `fp_status` at zero.
- R7: When `done` is high, `fp_exc` is 1 exactly when at least one `fp_status` bit is set. There is one such flag per operation.
- R8: Positive zero and negative zero compare as equal, and neither is less than the other.
- R9: Elements are evaluated in index order, 0 up to VL-1, one per clock, with the index shown on `elem_idx`. A VL above MAX_VL is treated as MAX_VL. `done` is a single-cycle pulse that comes max(VL,1) clock edges after the edge that accepts `start`.
- R10: `pred_bits` positions at VL and above are 0. VL = 0 writes an all-zero predicate.
- R11: An illegal instruction (a reserved code, an unsupported format, an unknown opcode or funct5, or nonzero reserved bits) raises `illegal` together with `done`, one edge after acceptance, and never raises `pred_we`.
- R12: On a legal operation, `pred_we` is high only in the `done` cycle, with `pred_addr` and `pred_bits` valid.
- R13: `start` is ignored while `busy` is high.
- R14: After reset, `busy`, `done`, `pred_we`, `illegal`, `fp_exc` and `pred_bits` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an operation (accepted when not busy) |
| insn | input | 32 | Instruction word |
| vl | input | $clog2(MAX_VL+1) | Vector length |
| busy | output | 1 | Operation in progress |
| elem_idx | output | $clog2(MAX_VL) | Index of the element whose operands are requested |
| op_a | input | XLEN | First source element at `elem_idx` |
| op_b | input | XLEN | Second source element at `elem_idx` |
| done | output | 1 | Single-cycle end-of-operation pulse |
| illegal | output | 1 | Illegal instruction, valid with `done` |
| pred_we | output | 1 | Predicate register write strobe |
| pred_addr | output | 5 | Destination predicate register number |
| pred_bits | output | MAX_VL | Predicate bitfield, one bit per element |
| fp_status | output | MAX_VL | Per-element invalid-operation status |
| fp_exc | output | 1 | Summary exception flag for the operation |

## Verification
The integer compares run over one operand set chosen so that the six compares give six different bitfields. The set holds equal pairs, pairs that differ in each direction, and pairs where signed and unsigned order disagree (all-ones against one, minimum against maximum). A wrong funct3 mapping or a wrong signedness therefore shows up as a distinct wrong pattern. The floating-point compares run in both precisions over a set that holds a sign split, a pair of magnitudes that are both negative, +0 against -0, a quiet NaN and a signalling NaN. This separates NaN ordering, zero handling and the quiet/signalling status rule. Short, zero and oversized vector lengths, an ignored mid-run start, the element order, and every illegal encoding class are driven as directed cases.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_FPOP   = 7'b1010011;
  localparam logic [4:0] F5_FCMP    = 5'b10100;

  typedef enum logic [3:0] {
    CMP_EQ, CMP_NE, CMP_LES, CMP_GES, CMP_LTU, CMP_GEU,
    CMP_FEQ, CMP_FLT, CMP_FLE, CMP_FNE
  } cmp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RUN, ST_DRAIN
  } seq_state_e;

  typedef struct packed {
    logic    illegal;
    logic    is_fp;
    logic    dbl;
    cmp_op_e op;
    logic [4:0] dst;
  } vpc_dec_t;

endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
  import vpc_pkg::*;
(
  input  logic [31:0] insn,
  output vpc_dec_t    dec
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [1:0] fmt;
  logic       code_ok;
  logic       unused_rs;

  assign opc       = insn[6:0];
  assign f3        = insn[14:12];
  assign fmt       = insn[26:25];
  assign unused_rs = ^insn[24:15];

  always_comb begin
    dec         = '0;
    dec.op      = CMP_EQ;
    code_ok     = 1'b0;
    if (opc == OPC_BRANCH) begin
      dec.dst = {1'b0, insn[11:8]};
      code_ok = 1'b1;
      case (f3)
        3'b000:  dec.op = CMP_EQ;
        3'b001:  dec.op = CMP_NE;
        3'b100:  dec.op = CMP_LES;
        3'b101:  dec.op = CMP_GES;
        3'b110:  dec.op = CMP_LTU;
        3'b111:  dec.op = CMP_GEU;
        default: code_ok = 1'b0;
      endcase
      dec.illegal = !code_ok || (insn[31:25] != 7'd0);
    end else if (opc == OPC_FPOP && insn[31:27] == F5_FCMP) begin
      dec.dst   = insn[11:7];
      dec.is_fp = 1'b1;
      dec.dbl   = (fmt == 2'b01);
      code_ok   = 1'b1;
      case (f3)
        3'b010:  dec.op = CMP_FEQ;
        3'b001:  dec.op = CMP_FLT;
        3'b000:  dec.op = CMP_FLE;
        3'b011:  dec.op = CMP_FNE;
        default: code_ok = 1'b0;
      endcase
      dec.illegal = !code_ok || fmt[1];
    end else begin
      dec.illegal = 1'b1;
    end
  end

endmodule

// File: rtl/vpc_int_cmp.sv
module vpc_int_cmp
  import vpc_pkg::*;
#(
  parameter int W = 64
) (
  input  cmp_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         res
);

  always_comb begin
    case (op)
      CMP_EQ:  res = (a == b);
      CMP_NE:  res = (a != b);
      CMP_LES: res = ($signed(a) <= $signed(b));
      CMP_GES: res = ($signed(a) >= $signed(b));
      CMP_LTU: res = (a < b);
      CMP_GEU: res = (a >= b);
      default: res = 1'b0;
    endcase
  end

endmodule

// File: rtl/vpc_fp_cmp.sv
module vpc_fp_cmp
  import vpc_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23,
  localparam int W = 1 + EW + MW
) (
  input  cmp_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         res,
  output logic         inv
);

  logic a_nan, b_nan, a_snan, b_snan, any_nan, any_snan;
  logic both_zero, eq, lt_raw;

  assign a_nan     = (&a[W-2:MW]) && (|a[MW-1:0]);
  assign b_nan     = (&b[W-2:MW]) && (|b[MW-1:0]);
  assign a_snan    = a_nan && !a[MW-1];
  assign b_snan    = b_nan && !b[MW-1];
  assign any_nan   = a_nan || b_nan;
  assign any_snan  = a_snan || b_snan;
  assign both_zero = (a[W-2:0] == '0) && (b[W-2:0] == '0);
  assign eq        = !any_nan && ((a == b) || both_zero);

  always_comb begin
    if (a[W-1] != b[W-1])
      lt_raw = a[W-1] && !both_zero;
    else if (!a[W-1])
      lt_raw = (a[W-2:0] < b[W-2:0]);
    else
      lt_raw = (a[W-2:0] > b[W-2:0]);
  end

  always_comb begin
    case (op)
      CMP_FEQ: begin res = eq;                        inv = any_snan; end
      CMP_FLT: begin res = !any_nan && lt_raw;        inv = any_nan;  end
      CMP_FLE: begin res = !any_nan && (lt_raw || eq); inv = any_nan; end
      CMP_FNE: begin res = !eq;                       inv = any_snan; end
      default: begin res = 1'b0;                      inv = 1'b0;     end
    endcase
  end

endmodule

// File: rtl/vpc_elem_eval.sv
module vpc_elem_eval
  import vpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cmp_op_e         op,
  input  logic            is_fp,
  input  logic            dbl,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            res,
  output logic            inv
);

  logic int_res, sp_res, sp_inv, dp_res, dp_inv;

  vpc_int_cmp #(.W(XLEN)) u_int (
    .op  (op),
    .a   (a),
    .b   (b),
    .res (int_res)
  );

  vpc_fp_cmp #(.EW(8), .MW(23)) u_sp (
    .op  (op),
    .a   (a[31:0]),
    .b   (b[31:0]),
    .res (sp_res),
    .inv (sp_inv)
  );

  generate
    if (XLEN >= 64) begin : g_dp
      vpc_fp_cmp #(.EW(11), .MW(52)) u_dp (
        .op  (op),
        .a   (a[63:0]),
        .b   (b[63:0]),
        .res (dp_res),
        .inv (dp_inv)
      );
    end else begin : g_no_dp
      assign dp_res = 1'b0;
      assign dp_inv = 1'b0;
    end
  endgenerate

  assign res = is_fp ? (dbl ? dp_res : sp_res) : int_res;
  assign inv = is_fp && (dbl ? dp_inv : sp_inv);

endmodule

// File: rtl/vpred_cmp_unit.sv
module vpred_cmp_unit
  import vpc_pkg::*;
#(
  parameter  int XLEN   = 64,
  parameter  int MAX_VL = 8,
  localparam int VLW    = $clog2(MAX_VL + 1),
  localparam int IDXW   = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic [VLW-1:0]    vl,
  output logic              busy,
  output logic [IDXW-1:0]   elem_idx,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  output logic              done,
  output logic              illegal,
  output logic              pred_we,
  output logic [4:0]        pred_addr,
  output logic [MAX_VL-1:0] pred_bits,
  output logic [MAX_VL-1:0] fp_status,
  output logic              fp_exc
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // decode and length clamp
  vpc_dec_t       dec_in, dec_q, dec_d;
  logic [VLW-1:0] vl_eff, vl_m1;

  vpc_decode u_dec (
    .insn (insn),
    .dec  (dec_in)
  );

  assign vl_eff = (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
  assign vl_m1  = vl_eff - VLW'(1);

  // state
  seq_state_e        state_q, state_d;
  logic [IDXW-1:0]   idx_q, idx_d, last_q, last_d;
  logic [MAX_VL-1:0] acc_q, acc_d, stat_q, stat_d;
  logic              exc_q, exc_d;
  logic              done_q, done_d, we_q, we_d, ill_q, ill_d;
  logic [4:0]        addr_q, addr_d;
  logic              op_load, elem_step, dp_en;
  logic              elem_res, elem_inv;

  assign op_load   = (state_q == ST_IDLE) && start;
  assign elem_step = (state_q == ST_RUN);
  assign dp_en     = op_load || elem_step;

  vpc_elem_eval #(.XLEN(XLEN)) u_eval (
    .op    (dec_q.op),
    .is_fp (dec_q.is_fp),
    .dbl   (dec_q.dbl),
    .a     (op_a),
    .b     (op_b),
    .res   (elem_res),
    .inv   (elem_inv)
  );

  // control next state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    we_d    = 1'b0;
    ill_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start)
          state_d = (dec_in.illegal || vl_eff == '0) ? ST_DRAIN : ST_RUN;
      end
      ST_RUN: begin
        if (idx_q == last_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          we_d    = 1'b1;
        end
      end
      ST_DRAIN: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        we_d    = !dec_q.illegal;
        ill_d   = dec_q.illegal;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // operation capture next state
  always_comb begin
    dec_d  = dec_q;
    addr_d = addr_q;
    last_d = last_q;
    if (op_load) begin
      dec_d  = dec_in;
      addr_d = dec_in.dst;
      last_d = IDXW'(vl_m1);
    end
  end

  // element datapath next state
  always_comb begin
    idx_d  = idx_q;
    acc_d  = acc_q;
    stat_d = stat_q;
    exc_d  = exc_q;
    if (op_load) begin
      idx_d  = '0;
      acc_d  = '0;
      stat_d = '0;
      exc_d  = 1'b0;
    end else if (elem_step) begin
      acc_d[idx_q]  = elem_res;
      stat_d[idx_q] = elem_inv;
      exc_d         = exc_q || elem_inv;
      idx_d         = idx_q + IDXW'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      we_q    <= we_d;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= '0;
      addr_q <= '0;
      last_q <= '0;
    end else if (op_load) begin
      dec_q  <= dec_d;
      addr_q <= addr_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      acc_q  <= '0;
      stat_q <= '0;
      exc_q  <= 1'b0;
    end else if (dp_en) begin
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      stat_q <= stat_d;
      exc_q  <= exc_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign elem_idx  = idx_q;
  assign done      = done_q;
  assign illegal   = ill_q;
  assign pred_we   = we_q;
  assign pred_addr = addr_q;
  assign pred_bits = acc_q;
  assign fp_status = stat_q;
  assign fp_exc    = exc_q;

endmodule

// File: rtl/vpred_cmp_chk.sv
module vpred_cmp_chk
  import vpc_pkg::*;
#(
  parameter  int XLEN   = 64,
  parameter  int MAX_VL = 8,
  localparam int VLW    = $clog2(MAX_VL + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [31:0]       insn,
  input logic [VLW-1:0]    vl,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              pred_we,
  input logic [MAX_VL-1:0] pred_bits,
  input logic [MAX_VL-1:0] fp_status,
  input logic              fp_exc
);

  logic [VLW-1:0]    cap_vl;
  logic              cap_fp;
  logic [VLW:0]      cnt;
  logic [MAX_VL-1:0] hi_mask;
  logic [VLW:0]      lat_exp;
  logic              unused_insn;

  assign unused_insn = ^insn[31:7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vl <= '0;
      cap_fp <= 1'b0;
      cnt    <= '0;
    end else if (start && !busy) begin
      cap_vl <= (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
      cap_fp <= (insn[6:0] == OPC_FPOP);
      cnt    <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_VL; i++)
      hi_mask[i] = (i >= int'(cap_vl));
  end

  assign lat_exp = (cap_vl == '0) ? (VLW+1)'(1) : {1'b0, cap_vl};

  // R12
  we_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_we |-> (done && !illegal));

  // R11
  illegal_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !pred_we && cnt == (VLW+1)'(1)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (cnt == lat_exp));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> ((pred_bits & hi_mask) == '0));

  // R7
  exc_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fp_exc == (fp_status != '0)));

  // R6
  status_fp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_fp) |-> (fp_status == '0));

endmodule

bind vpred_cmp_unit vpred_cmp_chk #(.XLEN(XLEN), .MAX_VL(MAX_VL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .insn      (insn),
  .vl        (vl),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .pred_we   (pred_we),
  .pred_bits (pred_bits),
  .fp_status (fp_status),
  .fp_exc    (fp_exc)
);

// File: tb/vpred_cmp_unit_tb.sv
module vpred_cmp_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  function automatic logic [31:0] int_insn(input logic [2:0] f3, input logic [3:0] preg,
                                           input logic [6:0] rsv);
    return {rsv, 5'd2, 5'd1, f3, preg, 1'b0, 7'b1100011};
  endfunction

  function automatic logic [31:0] fp_insn(input logic [4:0] f5, input logic [1:0] fmt,
                                          input logic [2:0] f3, input logic [4:0] rd);
    return {f5, fmt, 5'd2, 5'd1, f3, rd, 7'b1010011};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [3:0]  vl;
    logic [1:0]  set;
    logic        ill;
    logic [4:0]  addr;
    logic [7:0]  bits;
    logic [7:0]  stat;
    logic        exc;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R1 R2: integer compares, operand set 0
    '{int_insn(3'b000, 4'd3,  7'd0), 4'd8,  2'd0, 1'b0, 5'd3,  8'h41, 8'h00, 1'b0},
    '{int_insn(3'b001, 4'd4,  7'd0), 4'd8,  2'd0, 1'b0, 5'd4,  8'hBE, 8'h00, 1'b0},
    '{int_insn(3'b100, 4'd5,  7'd0), 4'd8,  2'd0, 1'b0, 5'd5,  8'hEB, 8'h00, 1'b0},
    '{int_insn(3'b101, 4'd6,  7'd0), 4'd8,  2'd0, 1'b0, 5'd6,  8'h55, 8'h00, 1'b0},
    '{int_insn(3'b110, 4'd7,  7'd0), 4'd8,  2'd0, 1'b0, 5'd7,  8'h92, 8'h00, 1'b0},
    '{int_insn(3'b111, 4'd15, 7'd0), 4'd8,  2'd0, 1'b0, 5'd15, 8'h6D, 8'h00, 1'b0},
    // R10: short, oversized (R9 clamp) and zero lengths
    '{int_insn(3'b110, 4'd1,  7'd0), 4'd5,  2'd0, 1'b0, 5'd1,  8'h12, 8'h00, 1'b0},
    '{int_insn(3'b000, 4'd2,  7'd0), 4'd12, 2'd0, 1'b0, 5'd2,  8'h41, 8'h00, 1'b0},
    '{int_insn(3'b000, 4'd2,  7'd0), 4'd0,  2'd0, 1'b0, 5'd2,  8'h00, 8'h00, 1'b0},
    // R3 R4 R5 R6 R8: double precision, set 1
    '{fp_insn(5'b10100, 2'b01, 3'b010, 5'd17), 4'd8, 2'd1, 1'b0, 5'd17, 8'h11, 8'h40, 1'b1},
    '{fp_insn(5'b10100, 2'b01, 3'b001, 5'd18), 4'd8, 2'd1, 1'b0, 5'd18, 8'h8A, 8'h60, 1'b1},
    '{fp_insn(5'b10100, 2'b01, 3'b000, 5'd19), 4'd8, 2'd1, 1'b0, 5'd19, 8'h9B, 8'h60, 1'b1},
    '{fp_insn(5'b10100, 2'b01, 3'b011, 5'd31), 4'd8, 2'd1, 1'b0, 5'd31, 8'hEE, 8'h40, 1'b1},
    // R4: single precision, set 2
    '{fp_insn(5'b10100, 2'b00, 3'b010, 5'd9),  4'd8, 2'd2, 1'b0, 5'd9,  8'h11, 8'h40, 1'b1},
    '{fp_insn(5'b10100, 2'b00, 3'b001, 5'd10), 4'd8, 2'd2, 1'b0, 5'd10, 8'h8A, 8'h60, 1'b1},
    '{fp_insn(5'b10100, 2'b00, 3'b000, 5'd11), 4'd8, 2'd2, 1'b0, 5'd11, 8'h9B, 8'h60, 1'b1},
    '{fp_insn(5'b10100, 2'b00, 3'b011, 5'd12), 4'd8, 2'd2, 1'b0, 5'd12, 8'hEE, 8'h40, 1'b1},
    // R7: no NaN reached, then one quiet NaN reached
    '{fp_insn(5'b10100, 2'b01, 3'b010, 5'd20), 4'd5, 2'd1, 1'b0, 5'd20, 8'h11, 8'h00, 1'b0},
    '{fp_insn(5'b10100, 2'b01, 3'b001, 5'd21), 4'd6, 2'd1, 1'b0, 5'd21, 8'h0A, 8'h20, 1'b1},
    // R11 R2: integer reserved codes and reserved bits
    '{int_insn(3'b010, 4'd1, 7'd0),  4'd8, 2'd0, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0},
    '{int_insn(3'b011, 4'd1, 7'd0),  4'd8, 2'd0, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0},
    '{int_insn(3'b000, 4'd1, 7'd1),  4'd8, 2'd0, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0},
    // R11 R4: unsupported formats; R3: bad funct3, bad funct5
    '{fp_insn(5'b10100, 2'b11, 3'b010, 5'd3), 4'd8, 2'd1, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0},
    '{fp_insn(5'b10100, 2'b10, 3'b010, 5'd3), 4'd8, 2'd1, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0},
    '{fp_insn(5'b10100, 2'b01, 3'b100, 5'd3), 4'd8, 2'd1, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0},
    '{fp_insn(5'b00000, 2'b01, 3'b010, 5'd3), 4'd8, 2'd1, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0},
    // R11: unknown opcode
    '{{7'd0, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, 4'd8, 2'd0, 1'b1, 5'd0, 8'h00, 8'h00, 1'b0}
  };

  localparam logic [63:0] S0A [8] = '{64'd5, 64'd3, 64'd7, '1, 64'd1,
                                      64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0};
  localparam logic [63:0] S0B [8] = '{64'd5, 64'd7, 64'd3, 64'd1, '1,
                                      64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1};
  localparam logic [63:0] S1A [8] = '{64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                                      64'h4000_0000_0000_0000, 64'hBFF0_0000_0000_0000,
                                      64'h0000_0000_0000_0000, 64'h7FF8_0000_0000_0000,
                                      64'h3FF0_0000_0000_0000, 64'hC000_0000_0000_0000};
  localparam logic [63:0] S1B [8] = '{64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000,
                                      64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                                      64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                                      64'h7FF0_0000_0000_0001, 64'hBFF0_0000_0000_0000};
  localparam logic [63:0] S2A [8] = '{64'h3F80_0000, 64'h3F80_0000, 64'h4000_0000, 64'hBF80_0000,
                                      64'h0000_0000, 64'h7FC0_0000, 64'h3F80_0000, 64'hC000_0000};
  localparam logic [63:0] S2B [8] = '{64'h3F80_0000, 64'h4000_0000, 64'h3F80_0000, 64'h3F80_0000,
                                      64'h8000_0000, 64'h3F80_0000, 64'h7F80_0001, 64'hBF80_0000};

  logic        clk, rst_n, start;
  logic [31:0] insn;
  logic [3:0]  vl;
  logic        busy, done, illegal, pred_we, fp_exc;
  logic [2:0]  elem_idx;
  logic [63:0] op_a, op_b;
  logic [4:0]  pred_addr;
  logic [7:0]  pred_bits, fp_status;
  logic [1:0]  cur_set;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  vpred_cmp_unit u_dut (
    .clk, .rst_n, .start, .insn, .vl, .busy, .elem_idx, .op_a, .op_b,
    .done, .illegal, .pred_we, .pred_addr, .pred_bits, .fp_status, .fp_exc
  );

  always_comb begin
    case (cur_set)
      2'd0:    begin op_a = S0A[elem_idx]; op_b = S0B[elem_idx]; end
      2'd1:    begin op_a = S1A[elem_idx]; op_b = S1B[elem_idx]; end
      default: begin op_a = S2A[elem_idx]; op_b = S2B[elem_idx]; end
    endcase
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected<=50000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives one operation and returns edges from acceptance to done
  task automatic run_op(input logic [31:0] i_insn, input logic [3:0] i_vl,
                        input logic [1:0] i_set, output int lat);
    @(negedge clk);
    start = 1'b1; insn = i_insn; vl = i_vl; cur_set = i_set;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    int lat_exp;
    int vle;
    int seen;
    int pos;
    logic fp;
    rst_n = 1'b0; start = 1'b0; insn = '0; vl = '0; cur_set = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R14 reset state
    chk("R14 busy after reset", busy, 0);
    chk("R14 done after reset", done, 0);
    chk("R14 pred_we after reset", pred_we, 0);
    chk("R14 illegal after reset", illegal, 0);
    chk("R14 fp_exc after reset", fp_exc, 0);
    chk("R14 pred_bits after reset", pred_bits, 0);

    for (int k = 0; k < NV; k++) begin
      run_op(VECS[k].insn, VECS[k].vl, VECS[k].set, lat);
      fp  = (VECS[k].insn[6:0] == 7'b1010011);
      vle = (VECS[k].vl > 8) ? 8 : int'(VECS[k].vl);
      lat_exp = (VECS[k].ill || vle == 0) ? 1 : vle;
      chk("R9 done latency", lat, lat_exp);
      chk("R11 illegal flag", illegal, VECS[k].ill);
      if (VECS[k].ill) begin
        chk("R11 no predicate write", pred_we, 0);
      end else begin
        chk("R12 write strobe with done", pred_we, 1);
        chk(fp ? "R3 destination rd" : "R2 destination register", pred_addr, VECS[k].addr);
        chk(fp ? "R3/R4/R5/R8 fp predicate" : "R1/R10 int predicate", pred_bits, VECS[k].bits);
        chk("R6 status bits", fp_status, VECS[k].stat);
        chk("R7 summary flag", fp_exc, VECS[k].exc);
      end
      @(negedge clk);
      chk("R12 write strobe single cycle", pred_we, 0);
    end

    // R9 element order: indices 0..7 one per clock
    @(negedge clk);
    start = 1'b1; insn = int_insn(3'b000, 4'd3, 7'd0); vl = 4'd8; cur_set = 2'd0;
    @(negedge clk);
    start = 1'b0;
    seen = 0; pos = 0;
    while (!done && pos < 40) begin
      if (busy) begin
        if (elem_idx != seen[2:0]) seen = 100;
        else seen++;
      end
      @(negedge clk);
      pos++;
    end
    chk("R9 element index sequence", seen, 8);

    // R13 start while busy is ignored
    run_op(int_insn(3'b000, 4'd3, 7'd0), 4'd8, 2'd0, lat);
    @(negedge clk);
    start = 1'b1; insn = int_insn(3'b000, 4'd3, 7'd0); vl = 4'd8;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R13 busy before second start", busy, 1);
    start = 1'b1; insn = int_insn(3'b001, 4'd9, 7'd0); vl = 4'd8;
    @(negedge clk);
    start = 1'b0;
    pos = 0;
    while (!done && pos < 40) begin
      @(negedge clk);
      pos++;
    end
    chk("R13 predicate of first op kept", pred_bits, 8'h41);
    chk("R13 destination of first op kept", pred_addr, 5'd3);
    seen = 0;
    repeat (12) begin
      @(negedge clk);
      if (done || busy) seen++;
    end
    chk("R13 ignored start not queued", seen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule